// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control around a 10-bit successive-approximation converter. It holds the start/busy bit, the completion flag and the result register. It steps the analog front end through each conversion in a fixed order: acquisition, bit-by-bit conversion, result update, then a mandatory settling gap with the capacitor array discharged. The analog array, the comparator and the conversion clock generator are outside the block. The conversion clock appears as a one-cycle tick input, and the comparator appears as a decision bit.

Software starts a conversion with a pulse on `go_set_i`, or one of two external event inputs starts it. Software can abort with `go_clr_i`. An aborted conversion never overwrites the stored result. The block has an internal-RC clock mode and a sleep input, which can power the converter down. When powered down it ignores all starts until the enable input is taken low. The block has no data stream: the result is a held register with no handshake, so back-pressure does not apply.

Top module: `sar_conv_seq`

## Requirements
- R1: When the last bit of a conversion is decided, the same clock edge clears `busy_o`, sets `flag_o` and loads the 10-bit code into `result_o`.
- R2: A `go_clr_i` pulse while a conversion or acquisition is in progress clears `busy_o` and enters the settling gap. `result_o` keeps the previous value and `flag_o` is not set.
- R3: After a completion or an abort, `discharge_o` stays high for exactly two conversion ticks. No acquisition or conversion starts before the gap ends, even if a start request is already pending.
- R4: Conversion takes one tick per bit, MSB first, over 10 ticks. `dac_code_o` shows the bits decided so far plus the current trial bit. `cmp_i`=1 at a tick keeps the trial bit and 0 clears it.
- R5: `acq_sel_i` codes 0..7 give an acquisition of 0, 2, 4, 6, 8, 12, 16 or 20 ticks with `sample_o` high. Code 0 goes straight to conversion.
- R6: `trig_sel_i`=0 makes `trig_a_evt_i` a start source and `trig_sel_i`=1 makes `trig_b_evt_i` a start source. The unselected event has no effect. An accepted event sets `busy_o`.
- R7: While `enable_i` is 0, start requests and events are ignored and `busy_o` is held at 0.
- R8: With `rc_clk_i`=1, conversion starts one extra tick after acquisition ends. If `irq_en_i`=0 at completion, `conv_on_o` drops to 0 and starts are ignored until `enable_i` goes low.
- R9: `sleep_i`=1 with `rc_clk_i`=0 while `busy_o` is set aborts the conversion, leaves `result_o` unchanged and drops `conv_on_o`.
- R10: `rst_n`=0 or `mod_disable_i`=1 returns `busy_o`, `flag_o` and `result_o` to 0 and holds them there. Ticks are ignored meanwhile.
- R11: A `flag_clr_i` pulse clears `flag_o`. A completion on the same edge wins.
- R12: At most one of `sample_o`, `hold_o` and `discharge_o` is high. `hold_o` is high during the extra RC tick and the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_disable_i | input | 1 | Holds the block in reset and gates its ticks |
| enable_i | input | 1 | Converter enable |
| go_set_i | input | 1 | Software start pulse |
| go_clr_i | input | 1 | Software abort pulse |
| flag_clr_i | input | 1 | Completion flag clear pulse |
| irq_en_i | input | 1 | Completion interrupt enable |
| rc_clk_i | input | 1 | Internal RC conversion clock selected |
| sleep_i | input | 1 | Device in sleep |
| trig_sel_i | input | 1 | Event source select |
| trig_a_evt_i | input | 1 | Event source 0 (compare event) |
| trig_b_evt_i | input | 1 | Event source 1 (charge-timing event) |
| acq_sel_i | input | 3 | Acquisition length code |
| tick_i | input | 1 | Conversion clock tick, one cycle wide |
| cmp_i | input | 1 | Comparator decision, 1 when input ≥ DAC |
| busy_o | output | 1 | Start/busy bit |
| flag_o | output | 1 | Completion flag |
| result_o | output | 10 | Last completed result |
| dac_code_o | output | 10 | Trial code to the DAC (0 outside hold) |
| sample_o | output | 1 | Channel connected to the array |
| hold_o | output | 1 | Array holding the sample |
| discharge_o | output | 1 | Array discharge |
| conv_on_o | output | 1 | Converter powered |

## Verification
The assertions check on every cycle that the result register changes only together with a set flag and a clear busy bit. They also check that a new flag always lands in the discharge gap, that the three phase controls never overlap, that a low enable forces busy off, and that a non-RC sleep always aborts. Only the bench's scenarios can show cycle counts: the 10-tick bit walk, each acquisition length, the extra RC tick and the two-tick gap. The bench scenarios also cover the converted values for several comparator models, and that the unselected trigger is ignored.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ACQ, PH_LAUNCH, PH_CONV, PH_GAP
  } phase_t;

  localparam int GAP_TICKS = 2;

  // acquisition ticks per code: 0,2,4,6,8 then steps of 4 up to 20
  function automatic logic [4:0] acq_len(input logic [2:0] code);
    logic [4:0] c;
    c = {2'b00, code};
    if (code <= 3'd4) return c << 1;
    else return 5'd8 + ((c - 5'd4) << 2);
  endfunction
endpackage

// File: rtl/sar_trig_gate.sv
module sar_trig_gate #(
  parameter int N_SRC = 2,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             go_set_i,
  output logic             start_req_o
);
  logic [N_SRC-1:0] picked;
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign picked[g] = evt_i[g] && (sel_i == SEL_W'(g));
  end
  assign start_req_o = go_set_i | (|picked);
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int RES_BITS = 10,
  localparam int IDX_W = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                run_i,
  input  logic                step_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] dac_o,
  output logic                done_o,
  output logic [RES_BITS-1:0] final_o
);
  logic [RES_BITS-1:0] code_q, trial_bit;
  logic [IDX_W-1:0]    idx_q;

  assign trial_bit = {{(RES_BITS-1){1'b0}}, 1'b1} << idx_q;
  assign dac_o     = code_q | trial_bit;
  assign done_o    = step_i && (idx_q == '0);
  assign final_o   = cmp_i ? dac_o : code_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      code_q <= '0;
      idx_q  <= IDX_W'(RES_BITS-1);
    end else if (!run_i) begin
      code_q <= '0;
      idx_q  <= IDX_W'(RES_BITS-1);
    end else if (step_i) begin
      code_q <= final_o;
      if (idx_q != '0) idx_q <= idx_q - 1'b1;
    end
  end
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                tick_i,
  input  logic                enable_i,
  input  logic                start_req_i,
  input  logic                go_clr_i,
  input  logic                flag_clr_i,
  input  logic                irq_en_i,
  input  logic                rc_clk_i,
  input  logic                sleep_i,
  input  logic [2:0]          acq_sel_i,
  input  logic                eng_done_i,
  input  logic [RES_BITS-1:0] eng_final_i,
  output logic                eng_run_o,
  output logic                busy_o,
  output logic                flag_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                sample_o,
  output logic                hold_o,
  output logic                discharge_o,
  output logic                conv_on_o
);
  phase_t             ph_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q, flag_q, pwr_off_q;
  logic [RES_BITS-1:0] res_q;
  logic [4:0]         acq_ticks;
  logic               active;

  assign acq_ticks = acq_len(acq_sel_i);
  assign active    = (ph_q == PH_ACQ) || (ph_q == PH_LAUNCH) || (ph_q == PH_CONV);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ph_q <= PH_IDLE; cnt_q <= '0; busy_q <= 1'b0;
      flag_q <= 1'b0; pwr_off_q <= 1'b0; res_q <= '0;
    end else begin
      if (flag_clr_i) flag_q <= 1'b0;
      if (!enable_i) begin
        busy_q <= 1'b0; ph_q <= PH_IDLE; pwr_off_q <= 1'b0;
      end else begin
        if (start_req_i && !busy_q && !pwr_off_q) busy_q <= 1'b1;
        if (sleep_i && !rc_clk_i && busy_q) begin
          busy_q <= 1'b0; pwr_off_q <= 1'b1;
          if (active) begin ph_q <= PH_GAP; cnt_q <= CNT_W'(GAP_TICKS); end
        end else if (go_clr_i && busy_q) begin
          busy_q <= 1'b0;
          if (active) begin ph_q <= PH_GAP; cnt_q <= CNT_W'(GAP_TICKS); end
        end else begin
          unique case (ph_q)
            PH_IDLE: if (busy_q) begin
              if (acq_ticks != '0) begin
                ph_q <= PH_ACQ; cnt_q <= CNT_W'(acq_ticks);
              end else ph_q <= rc_clk_i ? PH_LAUNCH : PH_CONV;
            end
            PH_ACQ: if (tick_i) begin
              if (cnt_q == CNT_W'(1)) ph_q <= rc_clk_i ? PH_LAUNCH : PH_CONV;
              else cnt_q <= cnt_q - 1'b1;
            end
            PH_LAUNCH: if (tick_i) ph_q <= PH_CONV;
            PH_CONV: if (eng_done_i) begin
              res_q  <= eng_final_i;
              busy_q <= 1'b0;
              flag_q <= 1'b1;
              ph_q   <= PH_GAP;
              cnt_q  <= CNT_W'(GAP_TICKS);
              if (rc_clk_i && !irq_en_i) pwr_off_q <= 1'b1;
            end
            PH_GAP: if (tick_i) begin
              if (cnt_q == CNT_W'(1)) ph_q <= PH_IDLE;
              else cnt_q <= cnt_q - 1'b1;
            end
            default: ph_q <= PH_IDLE;
          endcase
        end
      end
    end
  end

  assign eng_run_o   = (ph_q == PH_CONV);
  assign busy_o      = busy_q;
  assign flag_o      = flag_q;
  assign result_o    = res_q;
  assign conv_on_o   = enable_i && !pwr_off_q;
  assign sample_o    = (ph_q == PH_ACQ) || ((ph_q == PH_IDLE) && enable_i && !pwr_off_q);
  assign hold_o      = (ph_q == PH_LAUNCH) || (ph_q == PH_CONV);
  assign discharge_o = (ph_q == PH_GAP);

  // R1 / R2: the result only moves on a completion
  assert_result_on_done_R1: assert property (@(posedge clk) disable iff (!arst_n)
    !$stable(result_o) |-> (flag_o && !busy_o));
  // R3: a fresh flag always lands in the discharge gap
  assert_flag_in_gap_R3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(flag_o) |-> discharge_o);
  // R7: enable low forces busy off
  assert_disabled_idle_R7: assert property (@(posedge clk) disable iff (!arst_n)
    !enable_i |=> !busy_o);
  // R9: sleep on a non-RC clock aborts and powers down
  assert_sleep_abort_R9: assert property (@(posedge clk) disable iff (!arst_n)
    (sleep_i && !rc_clk_i && busy_o && enable_i) |=> (!busy_o && !conv_on_o));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mod_disable_i,
  input  logic                enable_i,
  input  logic                go_set_i,
  input  logic                go_clr_i,
  input  logic                flag_clr_i,
  input  logic                irq_en_i,
  input  logic                rc_clk_i,
  input  logic                sleep_i,
  input  logic                trig_sel_i,
  input  logic                trig_a_evt_i,
  input  logic                trig_b_evt_i,
  input  logic [2:0]          acq_sel_i,
  input  logic                tick_i,
  input  logic                cmp_i,
  output logic                busy_o,
  output logic                flag_o,
  output logic [RES_BITS-1:0] result_o,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic                sample_o,
  output logic                hold_o,
  output logic                discharge_o,
  output logic                conv_on_o
);
  logic arst_n, tick_g, start_req, eng_run, eng_done;
  logic [RES_BITS-1:0] eng_dac, eng_final;

  assign arst_n = rst_n & ~mod_disable_i;   // R10: disable holds reset
  assign tick_g = tick_i & ~mod_disable_i;

  sar_trig_gate #(.N_SRC(2)) u_trig (
    .sel_i(trig_sel_i), .evt_i({trig_b_evt_i, trig_a_evt_i}),
    .go_set_i(go_set_i), .start_req_o(start_req)
  );

  sar_bit_engine #(.RES_BITS(RES_BITS)) u_eng (
    .clk(clk), .arst_n(arst_n), .run_i(eng_run), .step_i(eng_run && tick_g),
    .cmp_i(cmp_i), .dac_o(eng_dac), .done_o(eng_done), .final_o(eng_final)
  );

  sar_seq_fsm #(.RES_BITS(RES_BITS), .CNT_W(5)) u_fsm (
    .clk(clk), .arst_n(arst_n), .tick_i(tick_g), .enable_i(enable_i),
    .start_req_i(start_req), .go_clr_i(go_clr_i), .flag_clr_i(flag_clr_i),
    .irq_en_i(irq_en_i), .rc_clk_i(rc_clk_i), .sleep_i(sleep_i),
    .acq_sel_i(acq_sel_i), .eng_done_i(eng_done), .eng_final_i(eng_final),
    .eng_run_o(eng_run), .busy_o(busy_o), .flag_o(flag_o), .result_o(result_o),
    .sample_o(sample_o), .hold_o(hold_o), .discharge_o(discharge_o),
    .conv_on_o(conv_on_o)
  );

  assign dac_code_o = hold_o ? eng_dac : '0;

  // R12: phase controls never overlap
  assert_phase_excl_R12: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({sample_o, hold_o, discharge_o}));
endmodule

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;
  logic clk = 0, rst_n = 0, mod_dis = 0, en = 0, go_set = 0, go_clr = 0;
  logic flag_clr = 0, irq_en = 1, rc = 0, sleep = 0, tsel = 0, ev_a = 0, ev_b = 0;
  logic [2:0] acq = 0;
  logic tick = 0, cmp;
  logic busy, flag, sample, hold, dis, con;
  logic [9:0] result, dac, target = 0;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;
  assign cmp = (dac <= target);

  sar_conv_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mod_disable_i(mod_dis), .enable_i(en),
    .go_set_i(go_set), .go_clr_i(go_clr), .flag_clr_i(flag_clr), .irq_en_i(irq_en),
    .rc_clk_i(rc), .sleep_i(sleep), .trig_sel_i(tsel), .trig_a_evt_i(ev_a),
    .trig_b_evt_i(ev_b), .acq_sel_i(acq), .tick_i(tick), .cmp_i(cmp),
    .busy_o(busy), .flag_o(flag), .result_o(result), .dac_code_o(dac),
    .sample_o(sample), .hold_o(hold), .discharge_o(dis), .conv_on_o(con)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1); repeat (n) @(negedge clk); endtask
  task automatic ticks(int n);
    repeat (n) begin tick = 1; @(negedge clk); tick = 0; end
  endtask
  task automatic p_go;  go_set = 1;   @(negedge clk); go_set = 0;   endtask
  task automatic p_clr; go_clr = 1;   @(negedge clk); go_clr = 0;   endtask
  task automatic p_fc;  flag_clr = 1; @(negedge clk); flag_clr = 0; endtask
  task automatic p_ea;  ev_a = 1;     @(negedge clk); ev_a = 0;     endtask
  task automatic p_eb;  ev_b = 1;     @(negedge clk); ev_b = 0;     endtask

  task automatic t_reset;
    chk("R10 busy", busy, 0); chk("R10 flag", flag, 0); chk("R10 result", result, 0);
    chk("R12 hold", hold, 0); chk("R12 discharge", dis, 0);
  endtask

  task automatic t_convert(logic [9:0] v);
    target = v;
    p_go; cyc();
    chk("R12 hold in conv", {hold, sample}, 2'b10);
    chk("R4 msb trial", dac, 10'h200);
    ticks(1);
    chk("R4 second trial", dac, {v[9], 1'b1, 8'h00});
    ticks(8);
    chk("R1 no flag early", flag, 0);
    ticks(1);
    chk("R1 flag/busy", {flag, busy}, 2'b10);
    chk("R1 result", result, v);
    chk("R3 discharge", dis, 1);
    ticks(1); chk("R3 gap tick1", dis, 1);
    ticks(1); chk("R3 gap over", {dis, sample}, 2'b01);
    p_fc; chk("R11 flag clear", flag, 0);
  endtask

  task automatic t_gap_pending;
    target = 10'h155; p_go; cyc(); ticks(10);
    p_go;
    chk("R3 pending busy", busy, 1);
    chk("R3 no hold in gap", {hold, dis}, 2'b01);
    ticks(1); chk("R3 still gap", {hold, dis}, 2'b01);
    ticks(1); cyc();
    chk("R3 conv after gap", hold, 1);
    ticks(10); chk("R1 second result", result, 10'h155);
    ticks(2); p_fc;
  endtask

  task automatic t_abort;
    logic [9:0] prev = result;
    target = 10'h0F0; p_go; cyc(); ticks(4);
    p_clr;
    chk("R2 busy cleared", busy, 0);
    chk("R2 result kept", result, prev);
    chk("R2 no flag", flag, 0);
    chk("R2 gap entered", dis, 1);
    ticks(2);
  endtask

  task automatic t_acq(logic [2:0] code, int len);
    acq = code; target = 10'h321;
    p_go; cyc();
    chk("R5 acq sampling", {sample, hold}, 2'b10);
    ticks(len - 1);
    chk("R5 acq not done", hold, 0);
    ticks(1);
    chk("R5 acq done", hold, 1);
    ticks(10); chk("R5 result", result, 10'h321);
    ticks(2); p_fc; acq = 0;
  endtask

  task automatic t_trig;
    tsel = 1; p_ea; chk("R6 unselected a", busy, 0);
    p_eb; chk("R6 selected b", busy, 1); p_clr;
    tsel = 0; p_eb; chk("R6 unselected b", busy, 0);
    p_ea; chk("R6 selected a", busy, 1); p_clr;
    chk("R6 cleanup", busy, 0);
  endtask

  task automatic t_enable;
    en = 0; cyc();
    p_ea; p_go;
    chk("R7 ignored when off", busy, 0);
    en = 1; cyc();
  endtask

  task automatic t_rc;
    rc = 1; irq_en = 0; target = 10'h2AA;
    p_go; cyc();
    chk("R8 launch hold", hold, 1);
    ticks(10); chk("R8 extra tick", flag, 0);
    ticks(1); chk("R8 done", {flag, result}, {1'b1, 10'h2AA});
    chk("R8 powered off", con, 0);
    ticks(2); p_go; chk("R8 start ignored", busy, 0);
    en = 0; cyc(); en = 1; cyc();
    chk("R8 power back", con, 1);
    rc = 0; irq_en = 1; p_fc;
  endtask

  task automatic t_sleep;
    logic [9:0] prev = result;
    target = 10'h3FF; p_go; cyc(); ticks(3);
    sleep = 1; cyc();
    chk("R9 aborted", busy, 0);
    chk("R9 powered off", con, 0);
    chk("R9 result kept", result, prev);
    sleep = 0; ticks(2);
    en = 0; cyc(); en = 1; cyc();
  endtask

  task automatic t_disable;
    target = 10'h0AB; p_go; cyc(); ticks(10); ticks(2);
    chk("R10 pre flag", flag, 1);
    p_go; cyc(); ticks(3);
    mod_dis = 1; cyc();
    chk("R10 disabled clears", {busy, flag, result}, 12'h0);
    ticks(12);
    chk("R10 ticks gated", {busy, flag, hold}, 3'b000);
    mod_dis = 0; cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(3); t_reset();
    rst_n = 1; cyc(); en = 1; cyc();
    t_convert(10'h2A5); t_convert(10'h3FF); t_convert(10'h000); t_convert(10'h001);
    t_gap_pending(); t_abort();
    t_acq(3'd2, 4); t_acq(3'd5, 12); t_acq(3'd7, 20);
    t_trig(); t_enable(); t_rc(); t_sleep(); t_disable();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule